// File: doc/BRIEF.md
# Charge Share and Polarity Sequencer

This block sits behind the line latch of a column driver and decides, for every column, what its output stage does after each line load. When a synchronized load event arrives, the block captures the column codes and the polarity input. It then holds all columns on a common node for a programmable number of clock cycles. After a one-cycle pause with every output stage released, it lets each column drive the level converted from its captured code.

Polarity is assigned by column parity from the single captured polarity bit, so neighbouring columns always sit on opposite sides of the common voltage. Toggling the polarity input on every line gives dot inversion. Toggling it every N lines gives N-line inversion.

Top module: `charge_share_seq`

## Requirements
- R1: After reset, and until the first load event, every column has share enable and drive enable low, and the captured codes and polarity are zero.
- R2: When a load event arrives with a share length S greater than zero, share enable is high on every column for exactly S cycles, starting in the cycle after the load.
- R3: Between the last share cycle and the first drive cycle, there is exactly one cycle with share enable and drive enable both low on all columns.
- R4: Drive enable stays high on every column from the end of the gap until the next load event.
- R5: A share length of zero skips the share phase. From idle, from the gap or from drive, drive enable is high in the cycle after the load. If the load arrives during a share phase, the sequence passes through the one-cycle gap first.
- R6: A load event during a share phase restarts the share count. Share enable then stays high for S cycles after the new load, and the new polarity and codes are captured.
- R7: Bit i of pol_high belongs to column number i+1, and a value of 1 selects the high-polarity reference set. When the captured polarity is 0, pol_high is 1 on odd bit indices and 0 on even ones. When the captured polarity is 1, this is reversed.
- R8: The code on col_codes[i*6 +: 6] at the load event appears on dac_code[i*6 +: 6] from the next cycle. It stays unchanged until the next load event, whatever col_codes does in between.
- R9: The polarity input is sampled only at a load event. Changes on it between load events have no effect on pol_high.
- R10: No column ever has share enable and drive enable high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_evt | input | 1 | Synchronized one-cycle line load event |
| pol_in | input | 1 | Polarity input, sampled at a load event |
| share_len | input | SHARE_W | Share phase length in clock cycles; 0 skips the share phase |
| col_codes | input | NUM_COLS*CODE_W | Latched codes from the line buffer, column i at [i*CODE_W +: CODE_W] |
| share_en | output | NUM_COLS | Per-column common-node share enable |
| drive_en | output | NUM_COLS | Per-column amplifier drive enable |
| pol_high | output | NUM_COLS | Per-column reference set select, 1 selects the high-polarity set |
| dac_code | output | NUM_COLS*CODE_W | Per-column code presented for conversion |

## Verification
Some properties are checked on every cycle by the assertions:
- share and drive are never asserted together on any column;
- a share phase is never followed directly by drive;
- any load with a nonzero length enters or restarts sharing;
- a zero length outside sharing goes straight to drive;
- the idle state holds until a load;
- the captured code and polarity change only at a load.

Other behaviour can be shown only by the bench's directed scenarios. These cover the exact share length counted from the load, the position of the single gap cycle, the parity mapping of polarity for both input values, and the extension of the share phase by a second load.

// File: rtl/csp_pkg.sv
// Shared types for the charge share and polarity sequencer.
package csp_pkg;
    // Line phase common to all columns.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHARE = 2'd1,
        PH_GAP   = 2'd2,
        PH_DRIVE = 2'd3
    } phase_t;
endpackage

// File: rtl/csp_phase_fsm.sv
// Phase sequencer: walks all columns through share, gap and drive after
// every load event. Assumes load_evt is already synchronized to clk and
// lasts one cycle per line. share_len is read only at a load event.
module csp_phase_fsm
    import csp_pkg::*;
#(
    parameter int SHARE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_evt,
    input  logic [SHARE_W-1:0] share_len,
    output phase_t             phase_o
);
    localparam logic [SHARE_W-1:0] LAST_CNT = SHARE_W'(1);

    phase_t             phase_q;
    phase_t             phase_d;
    logic [SHARE_W-1:0] cnt_q;
    logic [SHARE_W-1:0] cnt_d;
    logic               zero_len;

    assign zero_len = (share_len == '0);

    // Next phase and share counter from the current phase and the load event.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        if (load_evt) begin
            if (!zero_len) begin
                phase_d = PH_SHARE;
                cnt_d   = share_len;
            end else if (phase_q == PH_SHARE) begin
                phase_d = PH_GAP;
                cnt_d   = '0;
            end else begin
                phase_d = PH_DRIVE;
                cnt_d   = '0;
            end
        end else begin
            unique case (phase_q)
                PH_SHARE: begin
                    if (cnt_q == LAST_CNT) begin
                        phase_d = PH_GAP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - LAST_CNT;
                    end
                end
                PH_GAP:   phase_d = PH_DRIVE;
                default:  phase_d = phase_q;
            endcase
        end
    end

    // Phase and counter registers with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign phase_o = phase_q;

    AST_SHARE_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHARE) |=> (phase_q != PH_DRIVE)); // R3
    AST_SHARE_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SHARE) |-> (cnt_q != '0)); // R2
    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && !zero_len) |=> (phase_q == PH_SHARE)); // R6
    AST_ZERO_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && zero_len && phase_q != PH_SHARE) |=> (phase_q == PH_DRIVE)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !load_evt) |=> (phase_q == PH_IDLE)); // R1
    AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DRIVE && !load_evt) |=> (phase_q == PH_DRIVE)); // R4
endmodule

// File: rtl/csp_line_latch.sv
// Line capture: stores the column codes and the polarity bit at each load
// event and holds them for the whole line. Assumes col_codes is stable
// in the cycle of the load event.
module csp_line_latch #(
    parameter int NUM_COLS = 8,
    parameter int CODE_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_evt,
    input  logic                       pol_in,
    input  logic [NUM_COLS*CODE_W-1:0] col_codes,
    output logic                       pol_q,
    output logic [NUM_COLS*CODE_W-1:0] code_q
);
    // Capture codes and polarity on a load event, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            code_q <= '0;
        end else if (load_evt) begin
            pol_q  <= pol_in;
            code_q <= col_codes;
        end
    end

    AST_CODE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (code_q == $past(col_codes))); // R8
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_evt |=> $stable(code_q)); // R8
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_evt |=> $stable(pol_q)); // R9
endmodule

// File: rtl/csp_column_map.sv
// Column fan-out: turns the common phase and captured polarity into
// per-column enables and reference set selects. Bit index i is column
// number i+1, so odd-numbered columns sit on even indices.
module csp_column_map
    import csp_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int CODE_W   = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  phase_t                     phase,
    input  logic                       pol_q,
    input  logic [NUM_COLS*CODE_W-1:0] code_q,
    output logic [NUM_COLS-1:0]        share_en,
    output logic [NUM_COLS-1:0]        drive_en,
    output logic [NUM_COLS-1:0]        pol_high,
    output logic [NUM_COLS*CODE_W-1:0] dac_code
);
    logic in_share;
    logic in_drive;

    assign in_share = (phase == PH_SHARE);
    assign in_drive = (phase == PH_DRIVE);

    for (genvar g = 0; g < NUM_COLS; g++) begin : g_col
        localparam logic EVEN_NUMBERED = ((g % 2) == 1);
        // Per-column enables and parity-based polarity select.
        assign share_en[g] = in_share;
        assign drive_en[g] = in_drive;
        assign pol_high[g] = pol_q ^ EVEN_NUMBERED;
        assign dac_code[g*CODE_W +: CODE_W] = code_q[g*CODE_W +: CODE_W];
    end

    AST_SHARE_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(share_en & drive_en))); // R10
endmodule

// File: rtl/charge_share_seq.sv
// Charge share and polarity sequencer top: captures a line at each load
// event, then sequences all columns through share, gap and drive, with
// polarity alternating by column parity.
module charge_share_seq
    import csp_pkg::*;
#(
    parameter int NUM_COLS = 8,
    parameter int CODE_W   = 6,
    parameter int SHARE_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_evt,
    input  logic                       pol_in,
    input  logic [SHARE_W-1:0]         share_len,
    input  logic [NUM_COLS*CODE_W-1:0] col_codes,
    output logic [NUM_COLS-1:0]        share_en,
    output logic [NUM_COLS-1:0]        drive_en,
    output logic [NUM_COLS-1:0]        pol_high,
    output logic [NUM_COLS*CODE_W-1:0] dac_code
);
    phase_t                     phase;
    logic                       pol_q;
    logic [NUM_COLS*CODE_W-1:0] code_q;

    csp_phase_fsm #(.SHARE_W(SHARE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_evt  (load_evt),
        .share_len (share_len),
        .phase_o   (phase)
    );

    csp_line_latch #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_evt  (load_evt),
        .pol_in    (pol_in),
        .col_codes (col_codes),
        .pol_q     (pol_q),
        .code_q    (code_q)
    );

    csp_column_map #(.NUM_COLS(NUM_COLS), .CODE_W(CODE_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase),
        .pol_q    (pol_q),
        .code_q   (code_q),
        .share_en (share_en),
        .drive_en (drive_en),
        .pol_high (pol_high),
        .dac_code (dac_code)
    );
endmodule

// File: tb/charge_share_seq_tb.sv
// Directed bench for the charge share and polarity sequencer. All tasks
// start and end just after a falling clock edge.
module charge_share_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam int CW = 6;
    localparam int SW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_evt = 1'b0;
    logic            pol_in = 1'b0;
    logic [SW-1:0]   share_len = '0;
    logic [NC*CW-1:0] col_codes = '0;
    logic [NC-1:0]   share_en, drive_en, pol_high;
    logic [NC*CW-1:0] dac_code;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    charge_share_seq #(.NUM_COLS(NC), .CODE_W(CW), .SHARE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .pol_in(pol_in),
        .share_len(share_len), .col_codes(col_codes), .share_en(share_en),
        .drive_en(drive_en), .pol_high(pol_high), .dac_code(dac_code)
    );

    function automatic logic [NC*CW-1:0] make_codes(int seed);
        logic [NC*CW-1:0] v;
        for (int i = 0; i < NC; i++) v[i*CW +: CW] = CW'((seed * 7 + i * 13 + 5) % 64);
        return v;
    endfunction

    function automatic logic [NC-1:0] exp_pol(logic p);
        logic [NC-1:0] v;
        for (int i = 0; i < NC; i++) v[i] = p ^ ((i % 2) == 1);
        return v;
    endfunction

    task automatic check_phase(logic es, logic ed, string req);
        n_checks++;
        if (share_en !== {NC{es}} || drive_en !== {NC{ed}}) begin
            n_fail++;
            $display("FAIL %s: share=%b drive=%b expected share=%b drive=%b",
                     req, share_en, drive_en, {NC{es}}, {NC{ed}});
        end
        n_checks++;
        if ((share_en & drive_en) != '0) begin
            n_fail++;
            $display("FAIL R10: overlap=%b expected %b", share_en & drive_en, {NC{1'b0}});
        end
    endtask

    task automatic check_line(logic [NC*CW-1:0] ec, logic ep, string req);
        n_checks++;
        if (dac_code !== ec) begin
            n_fail++;
            $display("FAIL %s: dac_code=%h expected %h", req, dac_code, ec);
        end
        n_checks++;
        if (pol_high !== exp_pol(ep)) begin
            n_fail++;
            $display("FAIL R7 %s: pol_high=%b expected %b", req, pol_high, exp_pol(ep));
        end
    endtask

    // Present a load for one cycle; returns after the capturing edge.
    task automatic do_load(logic p, int s, logic [NC*CW-1:0] c);
        load_evt  = 1'b1;
        pol_in    = p;
        share_len = SW'(s);
        col_codes = c;
        @(negedge clk);
        load_evt  = 1'b0;
    endtask

    // Check S share cycles, the gap and the first drive cycle.
    task automatic walk_share(int s);
        for (int j = 0; j < s; j++) begin
            check_phase(1'b1, 1'b0, "R2");
            @(negedge clk);
        end
        check_phase(1'b0, 1'b0, "R3");
        @(negedge clk);
        check_phase(1'b0, 1'b1, "R4");
    endtask

    task automatic t_reset();
        for (int j = 0; j < 4; j++) begin
            check_phase(1'b0, 1'b0, "R1");
            @(negedge clk);
        end
        check_line('0, 1'b0, "R1");
    endtask

    task automatic t_basic();
        logic [NC*CW-1:0] c = make_codes(1);
        do_load(1'b0, 3, c);
        check_line(c, 1'b0, "R8");
        walk_share(3);
        col_codes = make_codes(2);
        pol_in    = 1'b1;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check_phase(1'b0, 1'b1, "R4");
        end
        check_line(c, 1'b0, "R9");
    endtask

    task automatic t_pol_high();
        logic [NC*CW-1:0] c = make_codes(3);
        do_load(1'b1, 1, c);
        check_line(c, 1'b1, "R7");
        walk_share(1);
        @(negedge clk);
    endtask

    task automatic t_zero_len();
        logic [NC*CW-1:0] c = make_codes(4);
        do_load(1'b0, 0, c);
        check_phase(1'b0, 1'b1, "R5");
        check_line(c, 1'b0, "R5");
        @(negedge clk);
        check_phase(1'b0, 1'b1, "R5");
    endtask

    task automatic t_restart();
        logic [NC*CW-1:0] c = make_codes(6);
        do_load(1'b0, 4, make_codes(5));
        check_phase(1'b1, 1'b0, "R6");
        @(negedge clk);
        check_phase(1'b1, 1'b0, "R6");
        do_load(1'b1, 4, c);
        check_line(c, 1'b1, "R6");
        walk_share(4);
        @(negedge clk);
    endtask

    task automatic t_zero_in_share();
        logic [NC*CW-1:0] c = make_codes(8);
        do_load(1'b1, 3, make_codes(7));
        check_phase(1'b1, 1'b0, "R5");
        do_load(1'b0, 0, c);
        check_phase(1'b0, 1'b0, "R5");
        @(negedge clk);
        check_phase(1'b0, 1'b1, "R5");
        check_line(c, 1'b0, "R5");
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_pol_high();
        t_zero_len();
        t_restart();
        t_zero_in_share();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule